// File: doc/BRIEF.md
# Execute Unit with Equality Flag

This block is the arithmetic and compare stage of a small 8-bit processor. Each cycle it receives a 4-bit opcode, operand A (the value of the destination register) and operand B (either a second register or an immediate, already chosen upstream). It returns a write-back value and a write strobe for the register file in the same cycle, without any register on that path.

Equality compares do not produce a write-back value. Their outcome goes into a one-bit flag register, which the fetch stage uses to decide conditional branches. Branch and halt opcodes pass through without touching either the register file or the flag. Every opcode with no assigned meaning is a no-op.

The opcode is decoded one-hot. That decode drives both the result multiplexer and the write strobe, so a single decision controls what gets written and whether anything is written at all.

Top module: `exu_core`

## Requirements
- R1: While reset is asserted (active low), `flag_o` is 0, and an equality compare issued during reset leaves it at 0.
- R2: Opcode 4'h0 (add) drives `wr_en_o` high and `result_o` to (A + B) modulo 256 in the same cycle.
- R3: Opcode 4'h1 (subtract) drives `wr_en_o` high and `result_o` to (A − B) modulo 256 in the same cycle.
- R4: Opcode 4'h4 (move) drives `wr_en_o` high and `result_o` to B in the same cycle.
- R5: Opcode 4'h6 (compare-equal) keeps `wr_en_o` low. At the next rising clock edge `flag_o` becomes 1 if A equals B, and 0 otherwise.
- R6: Opcodes 4'h9, 4'hA and 4'hB (halt and the two branches) keep `wr_en_o` low, and `flag_o` is the same after the edge as before it.
- R7: Every other opcode (4'h2, 4'h3, 4'h5, 4'h7, 4'h8, 4'hC to 4'hF) keeps `wr_en_o` low and leaves `flag_o` unchanged.
- R8: Whenever `wr_en_o` is low, `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the flag updates on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the flag |
| opcode_i | input | 4 | Operation code |
| opa_i | input | 8 | Operand A, the destination register's current value |
| opb_i | input | 8 | Operand B, a register or immediate |
| result_o | output | 8 | Write-back value |
| wr_en_o | output | 1 | Register write strobe |
| flag_o | output | 1 | Equality flag for conditional branching |

## Verification
The bench drives wrapping sums and differences, such as 0xFF + 0x01 and 0x00 − 0x01. A design with a widened or saturating adder would return 0xFF or a carry-polluted value instead of 0x00 and 0xFF.

It sets the flag with a compare on equal operands, then issues branch, halt and unassigned opcodes whose operands differ. A design that treated any of these as a compare, or reloaded the flag on every cycle, would clear the flag early.

It also issues a compare on equal operands while reset is held. A flag that ignored reset would come out of reset set.

Finally, it sweeps every opcode with random operands and checks that the write strobe and the zeroed result agree. A decoder that wrote back on a compare would corrupt the destination register.

// File: rtl/exu_pkg.sv
package exu_pkg;

   localparam int unsigned OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD  = 4'h0,
      OPC_SUB  = 4'h1,
      OPC_MOV  = 4'h4,
      OPC_CEQ  = 4'h6,
      OPC_HALT = 4'h9,
      OPC_BFWD = 4'hA,
      OPC_BBWD = 4'hB
   } opc_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_ADD  = 2'd1,
      SEL_SUB  = 2'd2,
      SEL_MOV  = 2'd3
   } res_sel_e;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
   import exu_pkg::*;
#(
   parameter int unsigned OP_W = OPC_W
) (
   input  logic [OP_W-1:0] opcode_i,
   output res_sel_e        sel_o,
   output logic            wr_en_o,
   output logic            flag_ld_o
);
   localparam int unsigned NUM_OPC = 1 << OP_W;

   logic [NUM_OPC-1:0] hot;

   if (OP_W != OPC_W) begin : g_bad_width
      initial $fatal(1, "exu_decode: opcode width must be %0d", OPC_W);
   end

   for (genvar i = 0; i < NUM_OPC; i++) begin : g_hot
      assign hot[i] = (opcode_i == OP_W'(i));
   end

   always_comb begin
      sel_o = SEL_NONE;
      if (hot[OPC_ADD]) sel_o = SEL_ADD;
      if (hot[OPC_SUB]) sel_o = SEL_SUB;
      if (hot[OPC_MOV]) sel_o = SEL_MOV;
   end

   assign wr_en_o   = hot[OPC_ADD] | hot[OPC_SUB] | hot[OPC_MOV];
   assign flag_ld_o = hot[OPC_CEQ];

endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
   import exu_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter bit          SUB_BY_INV = 1'b1
) (
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  res_sel_e          sel_i,
   output logic [DATA_W-1:0] result_o,
   output logic              equal_o
);
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] diff;

   assign sum = opa_i + opb_i;

   if (SUB_BY_INV) begin : g_sub_inv
      assign diff = opa_i + (~opb_i) + DATA_W'(1);
   end else begin : g_sub_dir
      assign diff = opa_i - opb_i;
   end

   assign equal_o = &(opa_i ~^ opb_i);

   always_comb begin
      unique case (sel_i)
         SEL_ADD: result_o = sum;
         SEL_SUB: result_o = diff;
         SEL_MOV: result_o = opb_i;
         default: result_o = '0;
      endcase
   end

endmodule

// File: rtl/exu_flag.sv
module exu_flag #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic value_i,
   output logic flag_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_o <= RST_VAL;
      else if (load_i) flag_o <= value_i;
   end
endmodule

// File: rtl/exu_core.sv
module exu_core
   import exu_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter bit          SUB_BY_INV = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   output logic [DATA_W-1:0] result_o,
   output logic              wr_en_o,
   output logic              flag_o
);
   if (DATA_W < 2) begin : g_bad_data
      initial $fatal(1, "exu_core: DATA_W must be at least 2");
   end

   res_sel_e sel;
   logic     flag_ld;
   logic     equal;

   exu_decode #(.OP_W(OPC_W)) u_dec (
      .opcode_i (opcode_i),
      .sel_o    (sel),
      .wr_en_o  (wr_en_o),
      .flag_ld_o(flag_ld)
   );

   exu_datapath #(.DATA_W(DATA_W), .SUB_BY_INV(SUB_BY_INV)) u_dp (
      .opa_i   (opa_i),
      .opb_i   (opb_i),
      .sel_i   (sel),
      .result_o(result_o),
      .equal_o (equal)
   );

   exu_flag #(.RST_VAL(1'b0)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (flag_ld),
      .value_i(equal),
      .flag_o (flag_o)
   );

endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [3:0]        opcode_i,
   input logic [DATA_W-1:0] opa_i,
   input logic [DATA_W-1:0] opb_i,
   input logic [DATA_W-1:0] result_o,
   input logic              wr_en_o,
   input logic              flag_o
);
   always @(negedge clk_i) begin
      if (!rst_ni) a_r1_flag_reset: assert (flag_o == 1'b0);
   end

   a_r2_add_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (opcode_i == 4'h0) |-> (wr_en_o && result_o == DATA_W'(opa_i + opb_i)));

   a_r3_sub_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (opcode_i == 4'h1) |-> (wr_en_o && result_o == DATA_W'(opa_i - opb_i)));

   a_r4_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (opcode_i == 4'h4) |-> (wr_en_o && result_o == opb_i));

   a_r5_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (opcode_i == 4'h6) |-> !wr_en_o);

   a_r5_cmp_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (opcode_i == 4'h6) |=> (flag_o == $past(opa_i == opb_i)));

   a_r6_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (opcode_i inside {4'h9, 4'hA, 4'hB}) |=> (!$past(wr_en_o) && $stable(flag_o)));

   a_r7_nop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(opcode_i inside {4'h0, 4'h1, 4'h4, 4'h6, 4'h9, 4'hA, 4'hB})
      |=> (!$past(wr_en_o) && $stable(flag_o)));

   a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_o |-> (result_o == '0));

endmodule

bind exu_core exu_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .opcode_i(opcode_i),
   .opa_i   (opa_i),
   .opb_i   (opb_i),
   .result_o(result_o),
   .wr_en_o (wr_en_o),
   .flag_o  (flag_o)
);

// File: tb/exu_core_bench.sv
module exu_core_bench;
   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [3:0] opcode_i = 4'h0;
   logic [7:0] opa_i = 8'h00;
   logic [7:0] opb_i = 8'h00;
   logic [7:0] result_o;
   logic       wr_en_o;
   logic       flag_o;

   int total = 0;
   int bad = 0;
   bit model_flag = 1'b0;
   bit done = 1'b0;

   always #2 clk_i = ~clk_i;

   exu_core u_exu_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .opcode_i(opcode_i),
      .opa_i   (opa_i),
      .opb_i   (opb_i),
      .result_o(result_o),
      .wr_en_o (wr_en_o),
      .flag_o  (flag_o)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic string tag(input logic [3:0] op);
      case (op)
         4'h0: return "R2 add";
         4'h1: return "R3 sub";
         4'h4: return "R4 move";
         4'h6: return "R5 compare";
         4'h9, 4'hA, 4'hB: return "R6 control";
         default: return "R7 unassigned";
      endcase
   endfunction

   task automatic step(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
      int exp_res;
      bit exp_wr;
      @(negedge clk_i);
      opcode_i = op; opa_i = a; opb_i = b;
      #1;
      exp_wr = (op == 4'h0) || (op == 4'h1) || (op == 4'h4);
      case (op)
         4'h0: exp_res = (int'(a) + int'(b)) % 256;
         4'h1: exp_res = (int'(a) - int'(b) + 256) % 256;
         4'h4: exp_res = int'(b);
         default: exp_res = 0;
      endcase
      check({tag(op), " wr_en"}, int'(wr_en_o), int'(exp_wr));
      if (exp_wr) check({tag(op), " result"}, int'(result_o), exp_res);
      else check({"R8 idle result (", tag(op), ")"}, int'(result_o), 0);
      @(posedge clk_i);
      if (op == 4'h6) model_flag = (a == b);
      #1;
      check({tag(op), " flag"}, int'(flag_o), int'(model_flag));
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: compare of equal operands while reset is held must not set the flag
      @(negedge clk_i);
      opcode_i = 4'h6; opa_i = 8'h33; opb_i = 8'h33;
      @(posedge clk_i); #1;
      check("R1 flag in reset", int'(flag_o), 0);
      @(negedge clk_i);
      opcode_i = 4'hF;
      rst_ni = 1'b1;
      #1;
      check("R1 flag after release", int'(flag_o), 0);

      // R2/R3/R4 directed, including wrap corners
      step(4'h0, 8'hFF, 8'h01);
      step(4'h0, 8'h12, 8'h34);
      step(4'h1, 8'h00, 8'h01);
      step(4'h1, 8'h80, 8'h7F);
      step(4'h4, 8'h11, 8'hA5);
      // R5 set, then R6 / R7 must hold it with unequal operands
      step(4'h6, 8'h5A, 8'h5A);
      step(4'h9, 8'h01, 8'h02);
      step(4'hA, 8'h03, 8'h04);
      step(4'hB, 8'hFF, 8'h00);
      for (int o = 0; o < 16; o++) begin
         if (!(o inside {0, 1, 4, 6, 9, 10, 11})) step(4'(o), 8'hC3, 8'h3C);
      end
      // R5 clear, then R6 holds zero with equal operands
      step(4'h6, 8'h5A, 8'h5B);
      step(4'hB, 8'h77, 8'h77);
      step(4'h2, 8'h77, 8'h77);
      // random sweep over all opcodes
      for (int i = 0; i < 400; i++) begin
         logic [7:0] ra;
         logic [7:0] rb;
         ra = 8'($urandom);
         rb = (i % 5 == 0) ? ra : 8'($urandom);
         step(4'($urandom), ra, rb);
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule